// File: doc/BRIEF.md
# ADC Startup and First-Conversion Sequencer

This controller sits on the host side of an external successive-approximation converter. It owns the converter's reset, standby, range-select and conversion-start pins, and it takes the part from power-on or full shutdown to the point where its results can be trusted. It drives nothing until the supply monitor reports stable rails. It then releases the standby and range pins and waits a programmable wake-up time. Next it applies a reset pulse of programmable width and waits a programmable settling time. Last, it runs a programmable number of throw-away conversions before it accepts start requests from the host.

The converter reads the range-select pin when BUSY falls and applies that level to the following conversion. The default after reset is the wide range. When the host asks for the narrow range (range_sel low), the sequencer adds one extra dummy conversion, so that the requested range is in force before any result is flagged. In the ready state, each start request gives exactly one conversion-start pulse. The BUSY falling edge that ends that conversion gives a one-clock result_valid strobe. Raising shdn_req at any time parks the converter in full shutdown. Dropping it runs the whole wake, reset and dummy sequence again.

Timed phases last max(N,1) clock cycles for a configuration value N. BUSY is assumed to be synchronous to clk.

Top module: `adc_boot_seq`

## Requirements
- R1: After rst_n and until supply_ok is first seen high, adc_reset, adc_stby_n, adc_range, adc_convst, ready and result_valid are all 0.
- R2: Once supply_ok is high (or shdn_req is released), adc_stby_n and adc_range are 1 with adc_reset low for max(wake_cycles,1) cycles before adc_reset rises.
- R3: adc_reset is high for max(rst_width,1) consecutive cycles, and adc_stby_n and adc_range are 1 throughout.
- R4: After adc_reset falls, the settling phase lasts max(settle_cycles,1) cycles. With no dummy conversions due, ready rises right after that phase.
- R5: Between the reset fall and the rise of ready, exactly dummy_count + (range_sel==0 ? 1 : 0) adc_convst pulses are issued. Each one is completed by a BUSY falling edge.
- R6: adc_range is 1 during the wake, reset and settle phases. From the end of settling, it carries the range_sel level captured at that moment (1 = wide default, 0 = narrow).
- R7: adc_convst pulses last one cycle, and at most one conversion is outstanding. In ready, a start_req gives one pulse. A start_req outside ready has no effect.
- R8: result_valid is a one-cycle pulse, raised one cycle after a BUSY falling edge that ends a conversion started in ready. It is never raised for a dummy conversion. Results that the converter marks undefined are therefore never flagged.
- R9: One cycle after shdn_req is seen high, adc_stby_n, adc_range, adc_reset, adc_convst and ready are 0. Releasing shdn_req restarts the sequence at the wake-up wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_ok | input | 1 | Supplies reported stable |
| shdn_req | input | 1 | Request for full shutdown |
| wake_cycles | input | CW | Wake-up wait before the reset pulse |
| rst_width | input | CW | Reset pulse width in cycles |
| settle_cycles | input | CW | Wait after the reset pulse |
| dummy_count | input | DW | Initial results to discard |
| range_sel | input | 1 | Requested range, 1 = wide default, 0 = narrow |
| start_req | input | 1 | Host conversion request |
| busy | input | 1 | Converter BUSY, synchronous to clk |
| adc_reset | output | 1 | Converter reset pin |
| adc_stby_n | output | 1 | Converter standby pin, low = shut down |
| adc_range | output | 1 | Converter range-select pin |
| adc_convst | output | 1 | Conversion-start pulse |
| ready | output | 1 | Startup complete, host requests accepted |
| result_valid | output | 1 | One-cycle strobe for a trusted result |

## Verification
The assertions check on every cycle the properties that depend on no history:
- all pins stay quiet before the supply is reported;
- the reset pulse never overlaps standby or the narrow range;
- start pulses are single cycles;
- shutdown takes effect one cycle after the request;
- a result strobe appears only in ready and only just after a BUSY fall.

Some behaviours can only be shown by the bench scenarios, which drive a behavioural converter model that returns a garbage marker for undefined conversions. These are the exact lengths of the wake, reset and settle phases, the number of dummy conversions for each pair of discard count and range, and the fact that no garbage result is ever strobed valid across a sweep of configurations and restarts from shutdown.

// File: rtl/adc_boot_pkg.sv
package adc_boot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SUPPLY,
        ST_WAKE,
        ST_RESET,
        ST_SETTLE,
        ST_DUMMY,
        ST_READY,
        ST_SHDN
    } boot_state_e;

    // States in which the converter is powered and sequencing
    function automatic logic is_active(boot_state_e s);
        return (s == ST_WAKE) || (s == ST_RESET) || (s == ST_SETTLE) ||
               (s == ST_DUMMY) || (s == ST_READY);
    endfunction

endpackage

// File: rtl/boot_timer.sv
module boot_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (load) begin
            count_d = load_val;
        end else if (count_q != '0) begin
            count_d = count_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    // Phase ends in the cycle the count reaches one (or was loaded with zero)
    assign expired = (count_q <= CW'(1));

endmodule

// File: rtl/busy_edge.sv
module busy_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_in,
    output logic fall
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = busy_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

    assign fall = prev_q & ~busy_in;

endmodule

// File: rtl/adc_boot_seq.sv
module adc_boot_seq
    import adc_boot_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          supply_ok,
    input  logic          shdn_req,
    input  logic [CW-1:0] wake_cycles,
    input  logic [CW-1:0] rst_width,
    input  logic [CW-1:0] settle_cycles,
    input  logic [DW-1:0] dummy_count,
    input  logic          range_sel,
    input  logic          start_req,
    input  logic          busy,
    output logic          adc_reset,
    output logic          adc_stby_n,
    output logic          adc_range,
    output logic          adc_convst,
    output logic          ready,
    output logic          result_valid
);
    localparam int NW = DW + 1;

    typedef struct packed {
        boot_state_e   state;
        logic [NW-1:0] dleft;
        logic          pending;
        logic          rng;
        logic          convst;
        logic          valid;
    } seq_t;

    localparam seq_t SEQ_RST = '{state: ST_IDLE, dleft: '0, pending: 1'b0,
                                 rng: 1'b0, convst: 1'b0, valid: 1'b0};

    seq_t          d, q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          bfall;
    logic [NW-1:0] need;

    boot_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    busy_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy_in (busy),
        .fall    (bfall)
    );

    // Narrow range needs one extra conversion to latch it at a BUSY fall
    assign need = NW'(dummy_count) + NW'(!range_sel);

    always_comb begin
        d        = q;
        d.convst = 1'b0;
        d.valid  = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;

        case (q.state)
            ST_IDLE: d.state = ST_SUPPLY;
            ST_SUPPLY: begin
                if (supply_ok) begin
                    if (shdn_req) begin
                        d.state = ST_SHDN;
                    end else begin
                        d.state  = ST_WAKE;
                        tmr_load = 1'b1;
                        tmr_val  = wake_cycles;
                    end
                end
            end
            ST_SHDN: begin
                d.pending = 1'b0;
                if (!shdn_req) begin
                    d.state  = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = wake_cycles;
                end
            end
            ST_WAKE: begin
                if (tmr_done) begin
                    d.state  = ST_RESET;
                    tmr_load = 1'b1;
                    tmr_val  = rst_width;
                end
            end
            ST_RESET: begin
                if (tmr_done) begin
                    d.state  = ST_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = settle_cycles;
                end
            end
            ST_SETTLE: begin
                if (tmr_done) begin
                    d.rng     = range_sel;
                    d.dleft   = need;
                    d.pending = 1'b0;
                    d.state   = (need == '0) ? ST_READY : ST_DUMMY;
                end
            end
            ST_DUMMY: begin
                if (!q.pending) begin
                    d.convst  = 1'b1;
                    d.pending = 1'b1;
                end else if (bfall) begin
                    d.pending = 1'b0;
                    if (q.dleft <= NW'(1)) begin
                        d.state = ST_READY;
                        d.dleft = '0;
                    end else begin
                        d.dleft = q.dleft - 1'b1;
                    end
                end
            end
            ST_READY: begin
                if (q.pending) begin
                    if (bfall) begin
                        d.pending = 1'b0;
                        d.valid   = 1'b1;
                    end
                end else if (start_req) begin
                    d.convst  = 1'b1;
                    d.pending = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        // Shutdown request overrides every powered phase
        if (shdn_req && is_active(q.state)) begin
            d.state   = ST_SHDN;
            d.pending = 1'b0;
            d.convst  = 1'b0;
            d.valid   = 1'b0;
            tmr_load  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= SEQ_RST;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        adc_reset  = 1'b0;
        adc_stby_n = 1'b0;
        adc_range  = 1'b0;
        ready      = 1'b0;
        case (q.state)
            ST_WAKE, ST_SETTLE: begin
                adc_stby_n = 1'b1;
                adc_range  = 1'b1;
            end
            ST_RESET: begin
                adc_stby_n = 1'b1;
                adc_range  = 1'b1;
                adc_reset  = 1'b1;
            end
            ST_DUMMY: begin
                adc_stby_n = 1'b1;
                adc_range  = q.rng;
            end
            ST_READY: begin
                adc_stby_n = 1'b1;
                adc_range  = q.rng;
                ready      = 1'b1;
            end
            default: ;
        endcase
    end

    assign adc_convst   = q.convst;
    assign result_valid = q.valid;

endmodule

// File: rtl/adc_boot_seq_chk.sv
module adc_boot_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic shdn_req,
    input logic busy,
    input logic adc_reset,
    input logic adc_stby_n,
    input logic adc_range,
    input logic adc_convst,
    input logic ready,
    input logic result_valid
);
    logic sup_seen_d, sup_seen_q;

    always_comb begin
        sup_seen_d = sup_seen_q | supply_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_seen_q <= 1'b0;
        end else begin
            sup_seen_q <= sup_seen_d;
        end
    end

    a_r1_quiet_until_supply: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_seen_q |-> !adc_reset && !adc_stby_n && !adc_range && !adc_convst && !ready && !result_valid);

    a_r3_reset_powered: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset |-> adc_stby_n && adc_range && !adc_convst);

    a_r7_convst_single: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |=> !adc_convst);

    a_r7_convst_powered: assert property (@(posedge clk) disable iff (!rst_n)
        adc_convst |-> adc_stby_n && !adc_reset);

    a_r8_valid_in_ready: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ready);

    a_r8_valid_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $past(busy, 2) && !$past(busy));

    a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r9_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_req |=> !adc_stby_n && !adc_range && !adc_reset && !adc_convst && !ready);

endmodule

bind adc_boot_seq adc_boot_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .shdn_req     (shdn_req),
    .busy         (busy),
    .adc_reset    (adc_reset),
    .adc_stby_n   (adc_stby_n),
    .adc_range    (adc_range),
    .adc_convst   (adc_convst),
    .ready        (ready),
    .result_valid (result_valid)
);

// File: tb/adc_boot_seq_test.sv
module adc_boot_seq_test;
    localparam int CW = 16;
    localparam int DW = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, supply_ok, shdn_req, range_sel, start_req;
    logic [CW-1:0] wake_cycles, rst_width, settle_cycles;
    logic [DW-1:0] dummy_count;
    logic          busy;
    logic          adc_reset, adc_stby_n, adc_range, adc_convst, ready, result_valid;

    adc_boot_seq #(.CW(CW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .shdn_req(shdn_req),
        .wake_cycles(wake_cycles), .rst_width(rst_width), .settle_cycles(settle_cycles),
        .dummy_count(dummy_count), .range_sel(range_sel), .start_req(start_req),
        .busy(busy), .adc_reset(adc_reset), .adc_stby_n(adc_stby_n),
        .adc_range(adc_range), .adc_convst(adc_convst), .ready(ready),
        .result_valid(result_valid)
    );

    int vectors = 0;
    int misses  = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor and behavioural converter state
    int  undef_n, want_rng;
    int  rst_run, last_rst, wake_run, last_wake, post_run, last_post;
    int  conv_boot, last_dum, conv_rdy, valid_cnt, bad_valid;
    int  viol_r6, viol_r7, idx, brem, cur_rng, lat_rng;
    bit  phase_post, prev_rst, prev_rdy, prev_cv, last_garbage;

    always @(negedge clk) begin
        if (!rst_n) begin
            busy = 1'b0; brem = 0; idx = 0; lat_rng = 1; cur_rng = 1;
            rst_run = 0; last_rst = 0; wake_run = 0; last_wake = 0;
            post_run = 0; last_post = 0; conv_boot = 0; last_dum = 0;
            conv_rdy = 0; valid_cnt = 0; bad_valid = 0; viol_r6 = 0; viol_r7 = 0;
            phase_post = 0; prev_rst = 0; prev_rdy = 0; prev_cv = 0; last_garbage = 1;
        end else begin
            // Phase measurement
            if (!adc_stby_n) begin
                wake_run = 0; phase_post = 0;
            end else if (!adc_reset && !phase_post) begin
                wake_run++;
            end
            if (adc_reset && !prev_rst) begin
                last_wake = wake_run; rst_run = 0;
            end
            if (adc_reset) rst_run++;
            if (!adc_reset && prev_rst) begin
                last_rst = rst_run; phase_post = 1; post_run = 0; conv_boot = 0;
            end
            if (phase_post && !ready) begin
                post_run++;
                if (adc_convst) conv_boot++;
            end
            if (ready && !prev_rdy) begin
                last_post = post_run; last_dum = conv_boot;
            end
            if (adc_convst && ready) conv_rdy++;
            if (adc_reset && (!adc_range || !adc_stby_n)) viol_r6++;
            if (adc_convst && prev_cv) viol_r7++;
            if (result_valid) begin
                valid_cnt++;
                if (last_garbage) bad_valid++;
            end
            prev_rst = adc_reset; prev_rdy = ready; prev_cv = adc_convst;

            // Converter model: undefined results until configured, range latched at BUSY fall
            if (adc_reset) begin
                idx = 0; lat_rng = 1; busy = 1'b0; brem = 0;
            end else if (busy) begin
                brem--;
                if (brem == 0) begin
                    busy = 1'b0;
                    last_garbage = (idx < undef_n) || (cur_rng != want_rng);
                    idx++;
                    lat_rng = int'(adc_range);
                end
            end else if (adc_convst) begin
                busy = 1'b1; brem = 3; cur_rng = lat_rng;
            end
        end
    end

    task automatic wait_ready();
        int n = 0;
        while (!ready && n < 3000) begin
            @(negedge clk);
            n++;
        end
        #1;
        check(ready == 1'b1, "R5 ready reached", int'(ready), 1);
    endtask

    task automatic convert(input int hold);
        int n = 0;
        int v0 = valid_cnt;
        int c0 = conv_rdy;
        start_req = 1'b1;
        for (int k = 0; k < hold; k++) @(negedge clk);
        start_req = 1'b0;
        while (!result_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        #1;
        check(valid_cnt == v0 + 1, "R8 one strobe per request", valid_cnt - v0, 1);
        check(conv_rdy == c0 + 1, "R7 one start pulse per request", conv_rdy - c0, 1);
        check(bad_valid == 0, "R8 no undefined result flagged", bad_valid, 0);
    endtask

    function automatic int atleast1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    initial begin
        #(8 * 150000);
        misses++;
        vectors++;
        $display("FAIL watchdog: got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int quiet_bad = 0;
        int wv[3] = '{0, 1, 3};
        int pv[3] = '{1, 2, 4};
        int sv[2] = '{1, 3};
        int dv[3] = '{0, 1, 2};
        rst_n = 0; supply_ok = 0; shdn_req = 0; range_sel = 1; start_req = 0;
        wake_cycles = 16'd2; rst_width = 16'd3; settle_cycles = 16'd2; dummy_count = '0;
        undef_n = 0; want_rng = 1;
        repeat (4) @(negedge clk);
        check({adc_reset, adc_stby_n, adc_range, adc_convst, ready, result_valid} == 6'b0,
              "R1 reset state", int'({adc_reset, adc_stby_n, adc_range, adc_convst, ready}), 0);
        rst_n = 1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (adc_reset || adc_stby_n || adc_range || adc_convst || ready) quiet_bad++;
        end
        check(quiet_bad == 0, "R1 pins quiet before supply", quiet_bad, 0);

        // First bring-up; a start request during wake must be ignored (R7)
        supply_ok = 1;
        @(negedge clk);
        start_req = 1;
        @(negedge clk);
        start_req = 0;
        wait_ready();
        check(last_wake == 2, "R2 wake length", last_wake, 2);
        check(last_rst == 3, "R3 reset width", last_rst, 3);
        check(last_post == 2, "R4 settle length", last_post, 2);
        check(last_dum == 0 && conv_rdy == 0, "R7 early start ignored", last_dum + conv_rdy, 0);
        convert(1);

        // Sweep of timings, discard counts and ranges through shutdown restarts
        for (int a = 0; a < 3; a++)
        for (int b = 0; b < 3; b++)
        for (int c = 0; c < 2; c++)
        for (int e = 0; e < 3; e++)
        for (int r = 0; r < 2; r++) begin
            shdn_req = 1;
            @(negedge clk);
            check(!adc_stby_n && !adc_range && !ready && !adc_reset, "R9 shutdown pins",
                  int'({adc_stby_n, adc_range, ready, adc_reset}), 0);
            wake_cycles = 16'(wv[a]); rst_width = 16'(pv[b]); settle_cycles = 16'(sv[c]);
            dummy_count = DW'(dv[e]); range_sel = r[0];
            undef_n = dv[e]; want_rng = r;
            @(negedge clk);
            shdn_req = 0;
            wait_ready();
            check(last_wake == atleast1(wv[a]), "R2 wake length", last_wake, atleast1(wv[a]));
            check(last_rst == atleast1(pv[b]), "R3 reset width", last_rst, atleast1(pv[b]));
            if (dv[e] == 0 && r == 1)
                check(last_post == sv[c], "R4 settle length", last_post, sv[c]);
            check(last_dum == dv[e] + (1 - r), "R5 dummy count", last_dum, dv[e] + (1 - r));
            check(int'(adc_range) == r, "R6 range pin after startup", int'(adc_range), r);
            convert(1);
            convert(2);
        end

        // Held request: still one start while a conversion is outstanding
        convert(3);

        check(viol_r6 == 0, "R6 wide range during reset", viol_r6, 0);
        check(viol_r7 == 0, "R7 single-cycle start pulses", viol_r7, 0);
        check(bad_valid == 0, "R8 no undefined result flagged overall", bad_valid, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule